// File: doc/BRIEF.md
# Burst-Gated Infrared Carrier Generator

This block makes the carrier waveform for an infrared remote-control transmitter. A carrier timer counts down through two alternating intervals, a high one and a low one. Each interval has its own reload value. The timer flips a phase bit every time a count runs out. A second 8-bit gating timer can count either the carrier's own underflows or an external prescaled tick. When auto-control is on, every underflow of the gating timer opens or closes a gate. The carrier therefore leaves the pin as bursts of pulses separated by silent gaps. A software-controlled carrier flag must be set before anything reaches the pin. When carrier generation is off, the flag alone drives the pin.

Software sets the block up through single-cycle write strobes that share one data bus. It reads both counters back, and it tests and acknowledges a sticky underflow flag for each timer. All control writes take effect on the clock edge that samples them.

Top module: `ir_carrier_gen`

## Requirements
- R1: After reset, `carr_o` is 0, both counters read 0, both underflow flags are 0, and all control bits are 0.
- R2: A running timer steps its counter down by one on each tick of its count source. On the tick where the counter is already 0, it reloads from its reload register. A loaded value n therefore divides the tick rate by n+1.
- R3: The carrier timer starts in the low phase and loads the low reload value. Each underflow flips the phase and loads the reload value of the new phase. With count source clk/2 (carrier control bit 0 = 0), the low phase lasts 2*(L+1) clocks and the high phase lasts 2*(H+1) clocks. Stopping the carrier returns the phase to low.
- R4: With the high-interval stretch bit set (carrier control bit 2 = 1), every high phase lasts one extra tick, so 2*(H+2) clocks from clk/2.
- R5: A gating-reload write made while the gating timer is stopped loads both its counter and its reload register. The same write made while the timer runs changes only the reload register. The low-reload write of the carrier timer follows the same rule.
- R6: Each timer's underflow flag is set by an underflow and cleared by its acknowledge strobe. When an underflow and an acknowledge arrive in the same cycle, the flag ends up set.
- R7: `car_set_i` sets the carrier flag and `car_clr_i` clears it. When carrier generation is off (carrier control bit 1 = 0), `carr_o` equals the carrier flag.
- R8: While the carrier flag is 0, `carr_o` is 0 even if carrier generation is running.
- R9: With auto-control on (gating control bit 2 = 1), each gating-timer underflow toggles the gate, and `carr_o` is held low while the gate is closed. With auto-control off, the gate is forced open. The gate starts open.
- R10: Gating control bit 1 selects the gating timer's count source: 0 selects `tick_pre_i`, 1 selects carrier-timer underflows. Gating control bit 0 runs the gating timer.
- R11: When carrier control bit 0 = 1, the carrier timer counts `tick_pre_i` pulses and ignores clock cycles that carry no tick.
- R12: A reload value of 0 gives an underflow on every tick of the count source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_pre_i | input | 1 | Prescaled count-enable tick |
| gctl_we_i | input | 1 | Write strobe for the gating control bits |
| gctl_wdata_i | input | 3 | Gating control: [2] auto-control, [1] source is carrier, [0] run |
| cctl_we_i | input | 1 | Write strobe for the carrier control bits |
| cctl_wdata_i | input | 3 | Carrier control: [2] high stretch, [1] carrier run, [0] source is tick_pre_i |
| gt_we_i | input | 1 | Gating-timer reload write (also loads the counter when stopped) |
| ct_lo_we_i | input | 1 | Carrier low-reload write (also loads the counter when stopped) |
| ct_hi_we_i | input | 1 | Carrier high-reload write |
| wdata_i | input | W | Shared write data for the reload writes |
| car_set_i | input | 1 | Set the carrier flag |
| car_clr_i | input | 1 | Clear the carrier flag |
| gt_ack_i | input | 1 | Acknowledge (clear) the gating underflow flag |
| ct_ack_i | input | 1 | Acknowledge (clear) the carrier underflow flag |
| gt_cnt_o | output | W | Gating counter read-back |
| ct_cnt_o | output | W | Carrier counter read-back |
| gt_uf_o | output | 1 | Gating underflow flag |
| ct_uf_o | output | 1 | Carrier underflow flag |
| carr_o | output | 1 | Carrier output pin |

## Verification
The bench measures the length of steady-state high and low intervals in clock cycles. An off-by-one in the reload, in the stretch tick or in the clk/2 divider shows up as a width that is one or two clocks wrong. It counts rising edges across a gated window. A gate that toggles on the wrong carrier event, or that starts closed, gives a pulse count other than four. It also writes the gating reload while the timer runs, and a design that overwrites the live counter changes the read-back. Finally, it sends an acknowledge in the same cycle as an underflow, so a design that lets the clear win loses the flag.

// File: rtl/irc_pkg.sv
package irc_pkg;

    // Gating control register, bit 2 down to bit 0
    typedef struct packed {
        logic auto_en;    // burst gating by the gating timer
        logic gsrc_car;   // 1: count carrier underflows, 0: count tick_pre_i
        logic g_run;      // gating timer runs
    } gctl_t;

    // Carrier control register, bit 2 down to bit 0
    typedef struct packed {
        logic hi_ext;     // stretch each high interval by one tick
        logic c_run;      // carrier generation runs
        logic c_src_pre;  // 1: count tick_pre_i, 0: clk/2
    } cctl_t;

endpackage

// File: rtl/irc_reload_timer.sv
module irc_reload_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         tick_i,
    input  logic         wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         ack_i,
    output logic [W-1:0] cnt_o,
    output logic         uf_o,
    output logic         flag_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] rld;
        logic         flag;
    } tmr_t;

    tmr_t s_d, s_q;
    logic step;

    always_comb begin
        s_d  = s_q;
        step = run_i & tick_i;
        uf_o = step & (s_q.cnt == '0);
        if (step) begin
            s_d.cnt = uf_o ? s_q.rld : s_q.cnt - 1'b1;
        end
        if (wr_i) begin
            s_d.rld = wdata_i;
            if (!run_i) s_d.cnt = wdata_i;
        end
        if (ack_i) s_d.flag = 1'b0;
        if (uf_o)  s_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o  = s_q.cnt;
    assign flag_o = s_q.flag;

    AST_STOPPED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_i && !run_i) |=> (cnt_o == $past(wdata_i)));  // R5
    AST_DOWN_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt_o != '0) |=> (cnt_o == W'($past(cnt_o) - 1'b1)));  // R2
    AST_FLAG_ON_UF: assert property (@(posedge clk) disable iff (!rst_n)
        uf_o |=> flag_o);  // R6

endmodule

// File: rtl/irc_carrier_timer.sv
module irc_carrier_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run_i,
    input  logic         src_pre_i,
    input  logic         tick_pre_i,
    input  logic         hi_ext_i,
    input  logic         lo_wr_i,
    input  logic         hi_wr_i,
    input  logic [W-1:0] wdata_i,
    input  logic         ack_i,
    output logic [W-1:0] cnt_o,
    output logic         phase_o,
    output logic         uf_o,
    output logic         flag_o
);

    typedef struct packed {
        logic [W-1:0] cnt;
        logic [W-1:0] rlo;
        logic [W-1:0] rhi;
        logic         phase;
        logic         ext;
        logic         div;
        logic         flag;
    } car_t;

    car_t s_d, s_q;
    logic tick, at_zero, stretch;

    always_comb begin
        s_d     = s_q;
        tick    = run_i & (src_pre_i ? tick_pre_i : s_q.div);
        at_zero = (s_q.cnt == '0);
        stretch = tick & at_zero & s_q.phase & hi_ext_i & ~s_q.ext;
        uf_o    = tick & at_zero & ~stretch;

        s_d.div = (run_i & ~src_pre_i) ? ~s_q.div : 1'b0;

        if (!run_i) begin
            s_d.phase = 1'b0;
            s_d.ext   = 1'b0;
        end else if (stretch) begin
            s_d.ext = 1'b1;
        end else if (uf_o) begin
            s_d.phase = ~s_q.phase;
            s_d.ext   = 1'b0;
            s_d.cnt   = s_q.phase ? s_q.rlo : s_q.rhi;
        end else if (tick) begin
            s_d.cnt = s_q.cnt - 1'b1;
        end

        if (lo_wr_i) begin
            s_d.rlo = wdata_i;
            if (!run_i) s_d.cnt = wdata_i;
        end
        if (hi_wr_i) s_d.rhi = wdata_i;

        if (ack_i) s_d.flag = 1'b0;
        if (uf_o)  s_d.flag = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o   = s_q.cnt;
    assign phase_o = s_q.phase;
    assign flag_o  = s_q.flag;

    AST_UF_FLIPS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        uf_o |=> (phase_o != $past(phase_o)));  // R3
    AST_STOP_GOES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !phase_o);  // R3
    AST_STRETCH_HOLDS_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        stretch |=> (phase_o && cnt_o == '0));  // R4

endmodule

// File: rtl/ir_carrier_gen.sv
module ir_carrier_gen #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_pre_i,
    input  logic         gctl_we_i,
    input  logic [2:0]   gctl_wdata_i,
    input  logic         cctl_we_i,
    input  logic [2:0]   cctl_wdata_i,
    input  logic         gt_we_i,
    input  logic         ct_lo_we_i,
    input  logic         ct_hi_we_i,
    input  logic [W-1:0] wdata_i,
    input  logic         car_set_i,
    input  logic         car_clr_i,
    input  logic         gt_ack_i,
    input  logic         ct_ack_i,
    output logic [W-1:0] gt_cnt_o,
    output logic [W-1:0] ct_cnt_o,
    output logic         gt_uf_o,
    output logic         ct_uf_o,
    output logic         carr_o
);
    import irc_pkg::*;

    typedef struct packed {
        gctl_t gctl;
        cctl_t cctl;
        logic  car;
        logic  gate;
    } top_t;

    top_t s_d, s_q;
    logic ct_uf, gt_uf, ct_phase, gt_tick;

    irc_carrier_timer #(.W(W)) u_car (
        .clk        (clk),
        .rst_n      (rst_n),
        .run_i      (s_q.cctl.c_run),
        .src_pre_i  (s_q.cctl.c_src_pre),
        .tick_pre_i (tick_pre_i),
        .hi_ext_i   (s_q.cctl.hi_ext),
        .lo_wr_i    (ct_lo_we_i),
        .hi_wr_i    (ct_hi_we_i),
        .wdata_i    (wdata_i),
        .ack_i      (ct_ack_i),
        .cnt_o      (ct_cnt_o),
        .phase_o    (ct_phase),
        .uf_o       (ct_uf),
        .flag_o     (ct_uf_o)
    );

    assign gt_tick = s_q.gctl.gsrc_car ? ct_uf : tick_pre_i;

    irc_reload_timer #(.W(W)) u_gate (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (s_q.gctl.g_run),
        .tick_i  (gt_tick),
        .wr_i    (gt_we_i),
        .wdata_i (wdata_i),
        .ack_i   (gt_ack_i),
        .cnt_o   (gt_cnt_o),
        .uf_o    (gt_uf),
        .flag_o  (gt_uf_o)
    );

    always_comb begin
        s_d = s_q;
        if (gctl_we_i) s_d.gctl = gctl_t'(gctl_wdata_i);
        if (cctl_we_i) s_d.cctl = cctl_t'(cctl_wdata_i);
        if (car_set_i) s_d.car = 1'b1;
        if (car_clr_i) s_d.car = 1'b0;
        if (!s_q.gctl.auto_en) s_d.gate = 1'b1;
        else if (gt_uf)        s_d.gate = ~s_q.gate;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.gate <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign carr_o = s_q.cctl.c_run ? (s_q.car & ct_phase & s_q.gate) : s_q.car;

    AST_NO_FLAG_NO_CARRIER: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.car |-> !carr_o);  // R8
    AST_GATE_CLOSED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (s_q.cctl.c_run && s_q.gctl.auto_en && !s_q.gate) |-> !carr_o);  // R9
    AST_GATE_OPEN_MANUAL: assert property (@(posedge clk) disable iff (!rst_n)
        !s_q.gctl.auto_en |=> s_q.gate);  // R9

endmodule

// File: tb/ir_carrier_gen_tb.sv
module ir_carrier_gen_tb;
    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         tick_pre_i = 1'b0;
    logic         gctl_we_i = 1'b0;
    logic [2:0]   gctl_wdata_i = '0;
    logic         cctl_we_i = 1'b0;
    logic [2:0]   cctl_wdata_i = '0;
    logic         gt_we_i = 1'b0;
    logic         ct_lo_we_i = 1'b0;
    logic         ct_hi_we_i = 1'b0;
    logic [W-1:0] wdata_i = '0;
    logic         car_set_i = 1'b0;
    logic         car_clr_i = 1'b0;
    logic         gt_ack_i = 1'b0;
    logic         ct_ack_i = 1'b0;
    logic [W-1:0] gt_cnt_o, ct_cnt_o;
    logic         gt_uf_o, ct_uf_o, carr_o;

    int checks = 0;
    int errors = 0;

    ir_carrier_gen #(.W(W)) u_dut (
        .clk(clk), .rst_n(rst_n), .tick_pre_i(tick_pre_i),
        .gctl_we_i(gctl_we_i), .gctl_wdata_i(gctl_wdata_i),
        .cctl_we_i(cctl_we_i), .cctl_wdata_i(cctl_wdata_i),
        .gt_we_i(gt_we_i), .ct_lo_we_i(ct_lo_we_i), .ct_hi_we_i(ct_hi_we_i),
        .wdata_i(wdata_i), .car_set_i(car_set_i), .car_clr_i(car_clr_i),
        .gt_ack_i(gt_ack_i), .ct_ack_i(ct_ack_i),
        .gt_cnt_o(gt_cnt_o), .ct_cnt_o(ct_cnt_o),
        .gt_uf_o(gt_uf_o), .ct_uf_o(ct_uf_o), .carr_o(carr_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual %0d expected %0d", 100000, 0);
        finish_run();
    end

    task automatic wr_gctl(input logic [2:0] v);
        @(negedge clk); gctl_we_i = 1'b1; gctl_wdata_i = v;
        @(negedge clk); gctl_we_i = 1'b0;
    endtask
    task automatic wr_cctl(input logic [2:0] v);
        @(negedge clk); cctl_we_i = 1'b1; cctl_wdata_i = v;
        @(negedge clk); cctl_we_i = 1'b0;
    endtask
    task automatic wr_gt(input logic [W-1:0] v);
        @(negedge clk); gt_we_i = 1'b1; wdata_i = v;
        @(negedge clk); gt_we_i = 1'b0;
    endtask
    task automatic wr_lo(input logic [W-1:0] v);
        @(negedge clk); ct_lo_we_i = 1'b1; wdata_i = v;
        @(negedge clk); ct_lo_we_i = 1'b0;
    endtask
    task automatic wr_hi(input logic [W-1:0] v);
        @(negedge clk); ct_hi_we_i = 1'b1; wdata_i = v;
        @(negedge clk); ct_hi_we_i = 1'b0;
    endtask
    task automatic car_set();
        @(negedge clk); car_set_i = 1'b1;
        @(negedge clk); car_set_i = 1'b0;
    endtask
    task automatic car_clr();
        @(negedge clk); car_clr_i = 1'b1;
        @(negedge clk); car_clr_i = 1'b0;
    endtask
    task automatic pulse_tick();
        @(negedge clk); tick_pre_i = 1'b1;
        @(negedge clk); tick_pre_i = 1'b0;
    endtask
    task automatic ack_all();
        @(negedge clk); gt_ack_i = 1'b1; ct_ack_i = 1'b1;
        @(negedge clk); gt_ack_i = 1'b0; ct_ack_i = 1'b0;
    endtask
    task automatic quiesce();
        wr_cctl(3'b000);
        wr_gctl(3'b000);
        ack_all();
    endtask

    // Waits for a rising carr_o, then returns the high and the low widths in clocks
    task automatic measure(output int hi, output int lo);
        int guard = 0;
        hi = 0; lo = 0;
        while (carr_o !== 1'b1 && guard < 200) begin @(negedge clk); guard++; end
        while (carr_o === 1'b1 && hi < 200) begin @(negedge clk); hi++; end
        while (carr_o === 1'b0 && lo < 200) begin @(negedge clk); lo++; end
    endtask

    task automatic count_rises(input int n, output int rises);
        logic prev = carr_o;
        rises = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (carr_o && !prev) rises++;
            prev = carr_o;
        end
    endtask

    task automatic t_reset();
        chk("R1 carr_o", carr_o, 0);
        chk("R1 gt_cnt", gt_cnt_o, 0);
        chk("R1 ct_cnt", ct_cnt_o, 0);
        chk("R1 flags", {gt_uf_o, ct_uf_o}, 0);
    endtask

    task automatic t_flag_direct();
        quiesce();
        car_set();
        chk("R7 flag set drives pin", carr_o, 1);
        car_clr();
        chk("R7 flag clear drives pin", carr_o, 0);
    endtask

    task automatic t_gate_timer();
        quiesce();
        wr_gt(8'd2);
        chk("R5 stopped write loads counter", gt_cnt_o, 2);
        wr_gctl(3'b001);  // run, source tick_pre_i (R10)
        pulse_tick();
        chk("R2 R10 first tick", gt_cnt_o, 1);
        repeat (3) @(negedge clk);
        chk("R10 no tick no count", gt_cnt_o, 1);
        pulse_tick();
        chk("R2 reaches zero", gt_cnt_o, 0);
        chk("R6 no flag before underflow", gt_uf_o, 0);
        pulse_tick();
        chk("R2 reload on underflow", gt_cnt_o, 2);
        chk("R6 flag on underflow", gt_uf_o, 1);
        ack_all();
        chk("R6 ack clears flag", gt_uf_o, 0);
        pulse_tick();
        wr_gt(8'd7);
        chk("R5 running write keeps counter", gt_cnt_o, 1);
        pulse_tick();
        pulse_tick();
        chk("R5 new reload used", gt_cnt_o, 7);
        wr_gctl(3'b000);
        wr_gt(8'd0);
        wr_gctl(3'b001);
        ack_all();
        @(negedge clk); tick_pre_i = 1'b1; gt_ack_i = 1'b1;
        @(negedge clk); tick_pre_i = 1'b0; gt_ack_i = 1'b0;
        chk("R6 set wins over ack", gt_uf_o, 1);
        chk("R12 zero reload stays zero", gt_cnt_o, 0);
        ack_all();
        pulse_tick();
        chk("R12 underflow every tick", gt_uf_o, 1);
    endtask

    task automatic t_intervals();
        int hi, lo;
        quiesce();
        wr_lo(8'd2);
        wr_hi(8'd4);
        car_set();
        wr_cctl(3'b010);
        measure(hi, lo);
        chk("R3 high width", hi, 10);
        chk("R3 low width", lo, 6);
        chk("R6 carrier flag", ct_uf_o, 1);
        ack_all();
        chk("R6 carrier ack", ct_uf_o, 0);
        car_clr();
        count_rises(30, hi);
        chk("R8 silent without flag", hi, 0);
        quiesce();
        chk("R3 stop returns low", carr_o, 0);
        wr_lo(8'd1);
        wr_hi(8'd1);
        car_set();
        wr_cctl(3'b110);
        measure(hi, lo);
        chk("R4 stretched high", hi, 6);
        chk("R4 low unchanged", lo, 4);
        car_clr();
    endtask

    task automatic t_prescaled();
        quiesce();
        wr_lo(8'd0);
        wr_hi(8'd0);
        car_set();
        wr_cctl(3'b011);
        repeat (5) @(negedge clk);
        chk("R11 idle without tick", carr_o, 0);
        pulse_tick();
        chk("R11 R12 one tick to high", carr_o, 1);
        repeat (5) @(negedge clk);
        chk("R11 holds without tick", carr_o, 1);
        pulse_tick();
        chk("R12 one tick to low", carr_o, 0);
        car_clr();
    endtask

    task automatic t_burst();
        int r;
        quiesce();
        wr_lo(8'd1);
        wr_hi(8'd1);
        wr_gt(8'd3);
        wr_gctl(3'b111);  // auto, carrier source, run
        car_set();
        wr_cctl(3'b010);
        count_rises(46, r);
        chk("R9 R10 pulses with gating", r, 4);
        quiesce();
        wr_lo(8'd1);
        car_set();
        wr_cctl(3'b010);
        count_rises(46, r);
        chk("R9 pulses with gate forced open", r, 6);
        car_clr();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_flag_direct();
        t_gate_timer();
        t_intervals();
        t_prescaled();
        t_burst();
        finish_run();
    end

endmodule